// File: doc/BRIEF.md
# Instruction SRAM Fetch/Data Arbiter

This block sits in front of a single-port instruction SRAM. Two requesters share that SRAM. The first is an instruction-fetch port that performs single-cycle reads. The second is a data port that reads and writes the same array. The data port loads program code and reads constant tables while code runs. A data access holds the SRAM for two cycles. A data read presents its address in the first cycle and receives its data in the second. A data write presents its address in the first cycle and drives its data in the second.

Only one access can start in a cycle. A requester raises its request and holds the request and its operands until it sees its stall output low at a clock edge. That edge is the point of acceptance. When a fetch and a data access request in the same cycle, the data access is served first. A request that arrives during the second cycle of a data access is stalled until that access has finished. Read data is steered back only to the port that issued the read, using a registered owner tag.

The SRAM is modelled as synchronous. A read issued with `sram_en` high and `sram_we` low returns data on `sram_rdata` in the next cycle. A write issued with `sram_en` and `sram_we` high latches the address, and the array stores `sram_wdata` at the end of the following cycle. Reset is asserted asynchronously and released through a two-flop synchronizer.

Top module: `isram_arbiter`

## Requirements
- R1: A fetch request with no data request and no data access in progress sees `if_stall` low in its request cycle. Its read data appears on `if_rdata` with `if_rvalid` high in the next cycle.
- R2: When `if_req` and `d_req` are both high in an idle cycle, the data access is granted (`d_stall` low) and the fetch is stalled (`if_stall` high).
- R3: In the cycle after a data access is accepted, every active request is stalled, on both ports.
- R4: A data read accepted in one cycle returns `sram_rdata` on `d_rdata` with `d_rvalid` high in the next cycle.
- R5: A data write accepted in one cycle drives its write data on `sram_wdata` in the next cycle. A later fetch or data read of that address returns the written value.
- R6: Read data goes only to the owning port. The other port sees its valid flag low and its read data at zero. A write or an idle cycle produces no valid flag on either port.
- R7: A stall output is high exactly while that port requests and is not granted. It is never high without a request.
- R8: While reset is asserted, both valid flags are low, `sram_en` is low, and any request sees its stall high. An access in flight is abandoned. Two clock edges after reset is released, a fetch is served without stall.
- R9: `sram_en` pulses for exactly the cycle in which an access is accepted. It stays low in the second cycle of a data access and in cycles with no request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| if_req | input | 1 | Fetch request, held until not stalled |
| if_addr | input | ADDR_W | Fetch word address |
| if_stall | output | 1 | Fetch not accepted this cycle |
| if_rvalid | output | 1 | Fetch read data valid |
| if_rdata | output | DATA_W | Fetch read data, zero when not valid |
| d_req | input | 1 | Data request, held until not stalled |
| d_we | input | 1 | Data access is a write |
| d_addr | input | ADDR_W | Data word address |
| d_wdata | input | DATA_W | Data write value, captured on acceptance |
| d_stall | output | 1 | Data access not accepted this cycle |
| d_rvalid | output | 1 | Data read data valid |
| d_rdata | output | DATA_W | Data read data, zero when not valid |
| sram_en | output | 1 | SRAM access start |
| sram_we | output | 1 | SRAM access is a write |
| sram_addr | output | ADDR_W | SRAM word address |
| sram_wdata | output | DATA_W | SRAM write data, driven in the second write cycle |
| sram_rdata | input | DATA_W | SRAM read data, one cycle after a read start |

## Verification
The bench builds the arbiter with a 6-bit address and 16-bit data. With those values, a behavioural SRAM of 64 words can be filled completely with address-derived contents. Every read result can then be predicted, and written values can be told apart from the preloaded ones. These widths let the bench exercise write-then-fetch and write-then-data-read at chosen addresses. They also cover back-to-back data reads, same-cycle collisions, and requests that land in the busy second cycle. Reset is applied once at start-up and once while a data read is in flight.

// File: rtl/isram_arb_pkg.sv
package isram_arb_pkg;
  // Owner of the data returning from the SRAM in the current cycle
  typedef enum logic [1:0] {
    OWN_NONE  = 2'd0,
    OWN_FETCH = 2'd1,
    OWN_DATA  = 2'd2
  } owner_e;

  // Slot phase: free, or second cycle of a two-cycle data access
  typedef enum logic {
    PH_FREE = 1'b0,
    PH_BUSY = 1'b1
  } phase_e;
endpackage

// File: rtl/isram_arb_ctrl.sv
module isram_arb_ctrl
  import isram_arb_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  logic   if_req,
  input  logic   d_req,
  input  logic   d_we,
  output logic   grant_if,
  output logic   grant_d,
  output logic   busy,
  output logic   wr_q,
  output owner_e owner_q,
  output logic   if_stall,
  output logic   d_stall
);
  phase_e phase_q, phase_d;
  owner_e owner_d;
  logic   wr_d;

  // Grant and next-state logic: data port has priority in a free slot
  always_comb begin
    grant_d  = rst_n && (phase_q == PH_FREE) && d_req;
    grant_if = rst_n && (phase_q == PH_FREE) && if_req && !d_req;
    phase_d  = grant_d ? PH_BUSY : PH_FREE;
    wr_d     = grant_d && d_we;
    if (grant_if)            owner_d = OWN_FETCH;
    else if (grant_d && !d_we) owner_d = OWN_DATA;
    else                     owner_d = OWN_NONE;
    if_stall = if_req && !grant_if;
    d_stall  = d_req && !grant_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= PH_FREE;
      owner_q <= OWN_NONE;
      wr_q    <= 1'b0;
    end else begin
      phase_q <= phase_d;
      owner_q <= owner_d;
      wr_q    <= wr_d;
    end
  end

  assign busy = (phase_q == PH_BUSY);
endmodule

// File: rtl/isram_arb_wpath.sv
module isram_arb_wpath #(
  parameter int ADDR_W = 12,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              grant_d,
  input  logic              busy,
  input  logic              wr_q,
  input  logic [ADDR_W-1:0] d_addr,
  input  logic [DATA_W-1:0] d_wdata,
  output logic [ADDR_W-1:0] addr_q,
  output logic [DATA_W-1:0] wdata_out
);
  logic [DATA_W-1:0] wdata_q;
  logic [ADDR_W-1:0] addr_d;
  logic [DATA_W-1:0] wdata_d;

  // Clock enable: operands captured only when a data access is accepted
  always_comb begin
    addr_d  = addr_q;
    wdata_d = wdata_q;
    if (grant_d) begin
      addr_d  = d_addr;
      wdata_d = d_wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q  <= '0;
      wdata_q <= '0;
    end else begin
      addr_q  <= addr_d;
      wdata_q <= wdata_d;
    end
  end

  assign wdata_out = (busy && wr_q) ? wdata_q : '0;
endmodule

// File: rtl/isram_arb_rroute.sv
module isram_arb_rroute
  import isram_arb_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  owner_e            owner_q,
  input  logic [DATA_W-1:0] sram_rdata,
  output logic              if_rvalid,
  output logic [DATA_W-1:0] if_rdata,
  output logic              d_rvalid,
  output logic [DATA_W-1:0] d_rdata
);
  localparam int NPORT = 2;
  localparam owner_e PORT_OWN [NPORT] = '{OWN_FETCH, OWN_DATA};

  logic [NPORT-1:0]             vld;
  logic [NPORT-1:0][DATA_W-1:0] dat;

  for (genvar p = 0; p < NPORT; p++) begin : g_port
    assign vld[p] = (owner_q == PORT_OWN[p]);
    assign dat[p] = vld[p] ? sram_rdata : '0;
  end

  assign if_rvalid = vld[0];
  assign if_rdata  = dat[0];
  assign d_rvalid  = vld[1];
  assign d_rdata   = dat[1];
endmodule

// File: rtl/isram_arbiter.sv
module isram_arbiter
  import isram_arb_pkg::*;
#(
  parameter int ADDR_W = 12,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              if_req,
  input  logic [ADDR_W-1:0] if_addr,
  output logic              if_stall,
  output logic              if_rvalid,
  output logic [DATA_W-1:0] if_rdata,
  input  logic              d_req,
  input  logic              d_we,
  input  logic [ADDR_W-1:0] d_addr,
  input  logic [DATA_W-1:0] d_wdata,
  output logic              d_stall,
  output logic              d_rvalid,
  output logic [DATA_W-1:0] d_rdata,
  output logic              sram_en,
  output logic              sram_we,
  output logic [ADDR_W-1:0] sram_addr,
  output logic [DATA_W-1:0] sram_wdata,
  input  logic [DATA_W-1:0] sram_rdata
);
  localparam int SYNC_N = 2;

  logic [SYNC_N-1:0] rst_sync_q;
  logic              rst_int_n;
  logic              grant_if, grant_d, busy, wr_q;
  owner_e            owner_q;
  logic [ADDR_W-1:0] addr_q;

  // Reset: asserted asynchronously, released after SYNC_N edges
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= '0;
    else        rst_sync_q <= {rst_sync_q[SYNC_N-2:0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[SYNC_N-1];

  isram_arb_ctrl u_ctrl (
    .clk      (clk),
    .rst_n    (rst_int_n),
    .if_req   (if_req),
    .d_req    (d_req),
    .d_we     (d_we),
    .grant_if (grant_if),
    .grant_d  (grant_d),
    .busy     (busy),
    .wr_q     (wr_q),
    .owner_q  (owner_q),
    .if_stall (if_stall),
    .d_stall  (d_stall)
  );

  isram_arb_wpath #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_wpath (
    .clk       (clk),
    .rst_n     (rst_int_n),
    .grant_d   (grant_d),
    .busy      (busy),
    .wr_q      (wr_q),
    .d_addr    (d_addr),
    .d_wdata   (d_wdata),
    .addr_q    (addr_q),
    .wdata_out (sram_wdata)
  );

  isram_arb_rroute #(.DATA_W(DATA_W)) u_rroute (
    .owner_q    (owner_q),
    .sram_rdata (sram_rdata),
    .if_rvalid  (if_rvalid),
    .if_rdata   (if_rdata),
    .d_rvalid   (d_rvalid),
    .d_rdata    (d_rdata)
  );

  // SRAM command: one start per accepted access
  always_comb begin
    sram_en = grant_if || grant_d;
    sram_we = grant_d && d_we;
    if (busy)         sram_addr = addr_q;
    else if (grant_d) sram_addr = d_addr;
    else              sram_addr = if_addr;
  end
endmodule

// File: rtl/isram_arbiter_chk.sv
module isram_arbiter_chk (
  input logic clk,
  input logic rst_n,
  input logic if_req,
  input logic if_stall,
  input logic if_rvalid,
  input logic d_req,
  input logic d_we,
  input logic d_stall,
  input logic d_rvalid,
  input logic sram_en
);
  // R1: accepted fetch returns data next cycle
  p_fetch_next_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (if_req && !if_stall) |=> if_rvalid);

  // R2: data wins a same-cycle collision
  p_data_wins_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (if_req && d_req && !d_stall) |-> if_stall);

  // R3: every request stalls in the busy second cycle
  p_busy_stall_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (d_req && !d_stall) |=> ((!if_req || if_stall) && (!d_req || d_stall)));

  // R4: accepted data read returns data next cycle
  p_dread_next_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (d_req && !d_stall && !d_we) |=> d_rvalid);

  // R5, R6: a write produces no read data on either port
  p_write_quiet_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (d_req && !d_stall && d_we) |=> (!d_rvalid && !if_rvalid));

  // R6: at most one port owns the returning data
  p_one_owner_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !(if_rvalid && d_rvalid));

  // R7: stall only with a request
  p_stall_req_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ((if_stall |-> if_req) and (d_stall |-> d_req)));

  // R9: no access start in the busy second cycle
  p_busy_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (d_req && !d_stall) |=> !sram_en);

  // R9: an access start always serves some accepted request
  p_en_grant_r9: assert property (@(posedge clk) disable iff (!rst_n)
    sram_en |-> ((if_req && !if_stall) || (d_req && !d_stall)));
endmodule

bind isram_arbiter isram_arbiter_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .if_req    (if_req),
  .if_stall  (if_stall),
  .if_rvalid (if_rvalid),
  .d_req     (d_req),
  .d_we      (d_we),
  .d_stall   (d_stall),
  .d_rvalid  (d_rvalid),
  .sram_en   (sram_en)
);

// File: tb/isram_arbiter_tb.sv
module isram_arbiter_tb_top;
  localparam int CLK_P  = 10;
  localparam int AW     = 6;
  localparam int DW     = 16;
  localparam int DEPTH  = 1 << AW;

  typedef struct packed {
    logic          ir;
    logic [AW-1:0] ia;
    logic          dr;
    logic          dw;
    logic [AW-1:0] da;
    logic [DW-1:0] dwd;
    logic          e_is;
    logic          e_ds;
    logic          e_en;
    logic          e_iv;
    logic [DW-1:0] e_id;
    logic          e_dv;
    logic [DW-1:0] e_dd;
  } vec_t;

  localparam int NV = 22;
  localparam vec_t VECS [NV] = '{
    '{1'b0, 6'd0,  1'b0, 1'b0, 6'd0,  16'h0000, 1'b0, 1'b0, 1'b0, 1'b0, 16'h0000, 1'b0, 16'h0000},
    '{1'b1, 6'd1,  1'b0, 1'b0, 6'd0,  16'h0000, 1'b0, 1'b0, 1'b1, 1'b0, 16'h0000, 1'b0, 16'h0000},
    '{1'b1, 6'd2,  1'b0, 1'b0, 6'd0,  16'h0000, 1'b0, 1'b0, 1'b1, 1'b1, 16'hA001, 1'b0, 16'h0000},
    '{1'b0, 6'd0,  1'b0, 1'b0, 6'd0,  16'h0000, 1'b0, 1'b0, 1'b0, 1'b1, 16'hA002, 1'b0, 16'h0000},
    '{1'b1, 6'd3,  1'b1, 1'b0, 6'd5,  16'h0000, 1'b1, 1'b0, 1'b1, 1'b0, 16'h0000, 1'b0, 16'h0000},
    '{1'b1, 6'd3,  1'b0, 1'b0, 6'd0,  16'h0000, 1'b1, 1'b0, 1'b0, 1'b0, 16'h0000, 1'b1, 16'hA005},
    '{1'b1, 6'd3,  1'b0, 1'b0, 6'd0,  16'h0000, 1'b0, 1'b0, 1'b1, 1'b0, 16'h0000, 1'b0, 16'h0000},
    '{1'b0, 6'd0,  1'b1, 1'b1, 6'd7,  16'h1234, 1'b0, 1'b0, 1'b1, 1'b1, 16'hA003, 1'b0, 16'h0000},
    '{1'b1, 6'd7,  1'b0, 1'b0, 6'd0,  16'h0000, 1'b1, 1'b0, 1'b0, 1'b0, 16'h0000, 1'b0, 16'h0000},
    '{1'b1, 6'd7,  1'b0, 1'b0, 6'd0,  16'h0000, 1'b0, 1'b0, 1'b1, 1'b0, 16'h0000, 1'b0, 16'h0000},
    '{1'b0, 6'd0,  1'b1, 1'b0, 6'd7,  16'h0000, 1'b0, 1'b0, 1'b1, 1'b1, 16'h1234, 1'b0, 16'h0000},
    '{1'b0, 6'd0,  1'b1, 1'b0, 6'd8,  16'h0000, 1'b0, 1'b1, 1'b0, 1'b0, 16'h0000, 1'b1, 16'h1234},
    '{1'b0, 6'd0,  1'b1, 1'b0, 6'd8,  16'h0000, 1'b0, 1'b0, 1'b1, 1'b0, 16'h0000, 1'b0, 16'h0000},
    '{1'b0, 6'd0,  1'b0, 1'b0, 6'd0,  16'h0000, 1'b0, 1'b0, 1'b0, 1'b0, 16'h0000, 1'b1, 16'hA008},
    '{1'b1, 6'd9,  1'b1, 1'b1, 6'd9,  16'hBEEF, 1'b1, 1'b0, 1'b1, 1'b0, 16'h0000, 1'b0, 16'h0000},
    '{1'b1, 6'd9,  1'b0, 1'b0, 6'd0,  16'h0000, 1'b1, 1'b0, 1'b0, 1'b0, 16'h0000, 1'b0, 16'h0000},
    '{1'b1, 6'd9,  1'b0, 1'b0, 6'd0,  16'h0000, 1'b0, 1'b0, 1'b1, 1'b0, 16'h0000, 1'b0, 16'h0000},
    '{1'b0, 6'd0,  1'b0, 1'b0, 6'd0,  16'h0000, 1'b0, 1'b0, 1'b0, 1'b1, 16'hBEEF, 1'b0, 16'h0000},
    '{1'b0, 6'd0,  1'b1, 1'b0, 6'd10, 16'h0000, 1'b0, 1'b0, 1'b1, 1'b0, 16'h0000, 1'b0, 16'h0000},
    '{1'b0, 6'd0,  1'b1, 1'b0, 6'd11, 16'h0000, 1'b0, 1'b1, 1'b0, 1'b0, 16'h0000, 1'b1, 16'hA00A},
    '{1'b0, 6'd0,  1'b1, 1'b0, 6'd11, 16'h0000, 1'b0, 1'b0, 1'b1, 1'b0, 16'h0000, 1'b0, 16'h0000},
    '{1'b0, 6'd0,  1'b0, 1'b0, 6'd0,  16'h0000, 1'b0, 1'b0, 1'b0, 1'b0, 16'h0000, 1'b1, 16'hA00B}
  };

  logic          clk = 1'b0;
  logic          rst_n;
  logic          if_req, d_req, d_we;
  logic [AW-1:0] if_addr, d_addr;
  logic [DW-1:0] d_wdata;
  logic          if_stall, if_rvalid, d_stall, d_rvalid;
  logic [DW-1:0] if_rdata, d_rdata;
  logic          sram_en, sram_we;
  logic [AW-1:0] sram_addr;
  logic [DW-1:0] sram_wdata, sram_rdata;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  always #(CLK_P/2) clk = ~clk;

  isram_arbiter #(.ADDR_W(AW), .DATA_W(DW)) dut_i (
    .clk(clk), .rst_n(rst_n),
    .if_req(if_req), .if_addr(if_addr), .if_stall(if_stall),
    .if_rvalid(if_rvalid), .if_rdata(if_rdata),
    .d_req(d_req), .d_we(d_we), .d_addr(d_addr), .d_wdata(d_wdata),
    .d_stall(d_stall), .d_rvalid(d_rvalid), .d_rdata(d_rdata),
    .sram_en(sram_en), .sram_we(sram_we), .sram_addr(sram_addr),
    .sram_wdata(sram_wdata), .sram_rdata(sram_rdata)
  );

  // Behavioural SRAM: synchronous read, write data one cycle after address
  logic [DW-1:0] mem [DEPTH];
  logic          pend_w = 1'b0;
  logic [AW-1:0] pend_a = '0;
  initial begin
    for (int i = 0; i < DEPTH; i++) mem[i] = 16'hA000 + 16'(i);
    sram_rdata = '0;
  end
  always @(posedge clk) begin
    if (pend_w) mem[pend_a] <= sram_wdata;
    pend_w <= sram_en && sram_we;
    pend_a <= sram_addr;
    if (sram_en && !sram_we) sram_rdata <= mem[sram_addr];
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic drive(input logic ir, input logic [AW-1:0] ia, input logic dr,
                       input logic dw, input logic [AW-1:0] da, input logic [DW-1:0] dwd);
    if_req = ir; if_addr = ia; d_req = dr; d_we = dw; d_addr = da; d_wdata = dwd;
  endtask

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
  endtask

  initial begin
    #(CLK_P * 2000);
    if (!done) begin
      n_fail++;
      $display("FAIL R1..watchdog actual=running expected=finished");
      summary();
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0;
    drive(1'b0, '0, 1'b0, 1'b0, '0, '0);
    repeat (2) @(negedge clk);
    #(CLK_P/2 - 1);
    // R8: quiet outputs in reset
    chk("R8 if_rvalid in reset", 32'(if_rvalid), 0);
    chk("R8 d_rvalid in reset", 32'(d_rvalid), 0);
    chk("R8 sram_en in reset", 32'(sram_en), 0);
    @(negedge clk);
    drive(1'b1, 6'd1, 1'b0, 1'b0, '0, '0);
    #(CLK_P/2 - 1);
    chk("R8 if_stall request in reset", 32'(if_stall), 1);
    chk("R8 sram_en request in reset", 32'(sram_en), 0);
    @(negedge clk);
    drive(1'b0, '0, 1'b0, 1'b0, '0, '0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // Vector table walk
    for (int v = 0; v < NV; v++) begin
      @(negedge clk);
      drive(VECS[v].ir, VECS[v].ia, VECS[v].dr, VECS[v].dw, VECS[v].da, VECS[v].dwd);
      #(CLK_P/2 - 1);
      chk($sformatf("R2 R3 R7 if_stall v%0d", v), 32'(if_stall), 32'(VECS[v].e_is));
      chk($sformatf("R2 R3 R7 d_stall v%0d", v), 32'(d_stall), 32'(VECS[v].e_ds));
      chk($sformatf("R9 sram_en v%0d", v), 32'(sram_en), 32'(VECS[v].e_en));
      chk($sformatf("R1 R6 if_rvalid v%0d", v), 32'(if_rvalid), 32'(VECS[v].e_iv));
      chk($sformatf("R1 R5 R6 if_rdata v%0d", v), 32'(if_rdata), 32'(VECS[v].e_id));
      chk($sformatf("R4 R6 d_rvalid v%0d", v), 32'(d_rvalid), 32'(VECS[v].e_dv));
      chk($sformatf("R4 R5 R6 d_rdata v%0d", v), 32'(d_rdata), 32'(VECS[v].e_dd));
      // R5: write data appears in the second write cycle
      if (v == 8)  chk("R5 sram_wdata second cycle", 32'(sram_wdata), 32'h1234);
      if (v == 15) chk("R5 sram_wdata second cycle", 32'(sram_wdata), 32'hBEEF);
    end

    // R8: reset in the middle of a data read abandons it
    @(negedge clk);
    drive(1'b0, '0, 1'b1, 1'b0, 6'd4, '0);
    #(CLK_P/2 - 1);
    chk("R4 d_stall accept before reset", 32'(d_stall), 0);
    @(negedge clk);
    drive(1'b1, 6'd12, 1'b0, 1'b0, '0, '0);
    #1;
    rst_n = 1'b0;
    #(CLK_P/2 - 2);
    chk("R8 d_rvalid dropped by reset", 32'(d_rvalid), 0);
    chk("R8 if_stall under reset", 32'(if_stall), 1);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    #(CLK_P/2 - 1);
    chk("R8 R1 fetch served after release", 32'(if_stall), 0);
    @(negedge clk);
    drive(1'b0, '0, 1'b0, 1'b0, '0, '0);
    #(CLK_P/2 - 1);
    chk("R8 R1 fetch rvalid after release", 32'(if_rvalid), 1);
    chk("R8 R1 fetch data after release", 32'(if_rdata), 32'hA00C);
    chk("R6 d_rdata zero for fetch", 32'(d_rdata), 0);

    done = 1'b1;
    summary();
    $finish;
  end
endmodule